// File: doc/BRIEF.md
# Flash Programming Command Sequencer

This block runs complete non-volatile programming operations on a small microcontroller target. It sits one level above a shift engine that clocks the test access port. The shift engine takes an (instruction, data) request and reports when the shift is complete. For each operation the sequencer produces the full request list for one session:

- an opening pair that resets the target and unlocks programming;
- the command words for the operation, sent as 15-bit programming commands, with the write pulses grouped in fours;
- the wait intervals the target needs, counted in system clocks;
- for fuse writes, a repeated status poll;
- a closing group that leaves programming mode and releases the target.

A single start pulse selects one of four operations: chip erase, page write, page read-back with compare, or fuse-byte write. The caller gives a byte address and either a page data source or a fuse value. Page bytes pass between the page source and the shift engine through a byte index and a per-byte strobe. During read-back the sequencer compares every returned byte with the source page. It latches the first byte offset that differs.

Top module: `fps_sequencer`

## Requirements
- R1: Every session begins with instruction 0xC and data 0x0001, then instruction 0x4 and data 0xA370.
- R2: Operation code 0 (erase) sends the programming-command instruction 0x5 with the words 0x2380, 0x3180, 0x3380, 0x3380. The next request is held back for at least ERASE_CYC clocks and at most ERASE_CYC+8 clocks after the last of these is accepted.
- R3: Operation code 1 (page write) sends 0x2310, then 0x07hh, then 0x03ll, where hh:ll is the 16-bit word address (the byte address shifted right by one). It then sends a page load (instruction 0x6), then 0x3700, 0x3500, 0x3700, 0x3700. It then waits between WRITE_CYC and WRITE_CYC+8 clocks.
- R4: During a page load, the byte index starts at 0 and advances by one on each engine byte strobe. The byte on pg_data at each strobe is the next byte loaded, so PAGE_BYTES bytes go out in ascending order.
- R5: Operation code 2 (verify) sends 0x2302, the two address words and a page read (instruction 0x7). The read returns PAGE_BYTES+1 bytes. The first byte is discarded, and byte k+1 is compared with source byte k.
- R6: The first differing byte sets mismatch and latches its offset. Later differences do not move the offset. Both are cleared when the next operation starts.
- R7: Operation code 3 (fuse write) sends 0x2340, then 0x13vv with the fuse value, then four write words. fuse_sel 0 selects the low byte (0x3300, 0x3100, 0x3300, 0x3300). fuse_sel 1 selects the high byte (0x3700, 0x3500, 0x3700, 0x3700). fuse_sel 2 or 3 selects the extended byte (0x3B00, 0x3900, 0x3B00, 0x3B00).
- R8: After the fuse write words, 0x3700 is sent repeatedly until bit 9 of the response word is set (bit 1 of the second returned byte). If POLL_MAX polls go unanswered, fuse_err is set and the session still closes.
- R9: Every session ends with 0x2300, 0x3300, then instruction 0x4 with data 0, then instruction 0xC with data 0.
- R10: busy rises the cycle after an accepted start. done is a one-cycle pulse in the first cycle busy is low again. A start while busy is ignored.
- R11: After reset, the block is idle: busy, done, eng_valid, mismatch and fuse_err are low.
- R12: A request holds its instruction and data until eng_done. The request line is low for at least one cycle before the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| op | input | 2 | 0 erase, 1 page write, 2 verify, 3 fuse write |
| byte_addr | input | ADDR_W | Byte address of the page |
| fuse_sel | input | 2 | 0 low, 1 high, 2/3 extended fuse byte |
| fuse_val | input | 8 | Fuse value to write |
| pg_idx | output | IDX_W | Byte index into the page source |
| pg_data | input | 8 | Page source byte at pg_idx |
| eng_valid | output | 1 | Shift request pending |
| eng_instr | output | 4 | Instruction for the request |
| eng_data | output | 16 | Data word for the request |
| eng_done | input | 1 | Shift engine finished the request |
| eng_rdata | input | 16 | Word shifted out by the request |
| eng_byte_stb | input | 1 | One page byte moved by the engine |
| eng_rx_byte | input | 8 | Returned byte during page read |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished (one-cycle pulse) |
| mismatch | output | 1 | Read-back differed from source |
| mismatch_off | output | IDX_W | Offset of first differing byte |
| fuse_err | output | 1 | Fuse poll limit reached |

## Verification
The hardest case to reach from the ports is the fuse poll limit, and the boundary just before it. The bench's engine model withholds the completion bit for a chosen number of polls, so one run succeeds on the last allowed poll and another never succeeds and must still close the session. Mismatch latching is reached by changing the page source between a write and its read-back, at two offsets and then at the final offset only. A start pulse driven in the middle of an erase checks that the request stream is not disturbed.

// File: rtl/fps_pkg.sv
package fps_pkg;

    typedef enum logic [1:0] {
        OP_ERASE    = 2'd0,
        OP_PAGE_WR  = 2'd1,
        OP_PAGE_VFY = 2'd2,
        OP_FUSE_WR  = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        K_CMD, K_LOAD, K_READ, K_POLL, K_WAIT, K_END
    } kind_e;

    typedef struct packed {
        kind_e       kind;
        logic [3:0]  ir;
        logic [15:0] word;
    } step_t;

    localparam logic [3:0]  IR_RST   = 4'hC;
    localparam logic [3:0]  IR_PEN   = 4'h4;
    localparam logic [3:0]  IR_CMD   = 4'h5;
    localparam logic [3:0]  IR_PLOAD = 4'h6;
    localparam logic [3:0]  IR_PREAD = 4'h7;
    localparam logic [15:0] PEN_KEY  = 16'hA370;
    localparam int          POLL_BIT = 9;
    localparam int          STEP_W   = 5;

    function automatic step_t mk(kind_e k, logic [3:0] ir, logic [15:0] w);
        step_t s;
        s.kind = k;
        s.ir   = ir;
        s.word = w;
        return s;
    endfunction

    // second of a four-word pulse group drops bit 9
    function automatic logic [15:0] pulse_grp(logic [15:0] base, int k);
        return (k == 1) ? (base & 16'hFDFF) : base;
    endfunction

    function automatic logic [15:0] fuse_base(logic [1:0] sel);
        case (sel)
            2'd0:    return 16'h3300;
            2'd1:    return 16'h3700;
            default: return 16'h3B00;
        endcase
    endfunction

    function automatic int body_len(op_e op);
        case (op)
            OP_ERASE:    return 5;
            OP_PAGE_WR:  return 9;
            OP_PAGE_VFY: return 4;
            default:     return 7;
        endcase
    endfunction

    function automatic step_t seq_step(op_e op, logic [STEP_W-1:0] idx,
                                       logic [7:0] hh, logic [7:0] ll,
                                       logic [1:0] fsel, logic [7:0] fval);
        step_t s;
        int    j;
        int    t;
        s = mk(K_END, 4'h0, 16'h0);
        if (idx == 0) begin
            s = mk(K_CMD, IR_RST, 16'h0001);
        end else if (idx == 1) begin
            s = mk(K_CMD, IR_PEN, PEN_KEY);
        end else begin
            j = int'(idx) - 2;
            if (j < body_len(op)) begin
                case (op)
                    OP_ERASE: begin
                        if (j == 0)      s = mk(K_CMD, IR_CMD, 16'h2380);
                        else if (j == 1) s = mk(K_CMD, IR_CMD, 16'h3180);
                        else if (j < 4)  s = mk(K_CMD, IR_CMD, 16'h3380);
                        else             s = mk(K_WAIT, 4'h0, 16'h0001);
                    end
                    OP_PAGE_WR: begin
                        if (j == 0)      s = mk(K_CMD, IR_CMD, 16'h2310);
                        else if (j == 1) s = mk(K_CMD, IR_CMD, {8'h07, hh});
                        else if (j == 2) s = mk(K_CMD, IR_CMD, {8'h03, ll});
                        else if (j == 3) s = mk(K_LOAD, IR_PLOAD, 16'h0);
                        else if (j < 8)  s = mk(K_CMD, IR_CMD, pulse_grp(16'h3700, j - 4));
                        else             s = mk(K_WAIT, 4'h0, 16'h0000);
                    end
                    OP_PAGE_VFY: begin
                        if (j == 0)      s = mk(K_CMD, IR_CMD, 16'h2302);
                        else if (j == 1) s = mk(K_CMD, IR_CMD, {8'h07, hh});
                        else if (j == 2) s = mk(K_CMD, IR_CMD, {8'h03, ll});
                        else             s = mk(K_READ, IR_PREAD, 16'h0);
                    end
                    default: begin
                        if (j == 0)      s = mk(K_CMD, IR_CMD, 16'h2340);
                        else if (j == 1) s = mk(K_CMD, IR_CMD, {8'h13, fval});
                        else if (j < 6)  s = mk(K_CMD, IR_CMD, pulse_grp(fuse_base(fsel), j - 2));
                        else             s = mk(K_POLL, IR_CMD, 16'h3700);
                    end
                endcase
            end else begin
                t = j - body_len(op);
                case (t)
                    0:       s = mk(K_CMD, IR_CMD, 16'h2300);
                    1:       s = mk(K_CMD, IR_CMD, 16'h3300);
                    2:       s = mk(K_CMD, IR_PEN, 16'h0000);
                    3:       s = mk(K_CMD, IR_RST, 16'h0000);
                    default: s = mk(K_END, 4'h0, 16'h0);
                endcase
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/fps_step_rom.sv
module fps_step_rom
    import fps_pkg::*;
(
    input  op_e               op,
    input  logic [STEP_W-1:0] idx,
    input  logic [7:0]        hh,
    input  logic [7:0]        ll,
    input  logic [1:0]        fsel,
    input  logic [7:0]        fval,
    output step_t             step
);
    always_comb step = seq_step(op, idx, hh, ll, fsel, fval);
endmodule

// File: rtl/fps_interval.sv
module fps_interval #(
    parameter int LONG_CYC  = 500000,
    parameter int SHORT_CYC = 250000,
    localparam int MAXC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC,
    localparam int CW   = $clog2(MAXC + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic use_long,
    output logic expired
);
    logic [CW-1:0] cnt;
    logic          active;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            active <= 1'b0;
        end else if (load) begin
            cnt    <= use_long ? CW'(LONG_CYC - 1) : CW'(SHORT_CYC - 1);
            active <= 1'b1;
        end else if (active) begin
            if (cnt == '0) active <= 1'b0;
            else           cnt    <= cnt - 1'b1;
        end
    end

    assign expired = active && (cnt == '0);
endmodule

// File: rtl/fps_cmp.sv
module fps_cmp #(
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             en,
    input  logic [IDX_W-1:0] off,
    input  logic [7:0]       got,
    input  logic [7:0]       want,
    output logic             flag,
    output logic [IDX_W-1:0] flag_off
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            flag     <= 1'b0;
            flag_off <= '0;
        end else if (en && !flag && (got != want)) begin
            flag     <= 1'b1;
            flag_off <= off;
        end
    end
endmodule

// File: rtl/fps_sequencer.sv
module fps_sequencer
    import fps_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int PAGE_BYTES = 128,
    parameter int ERASE_CYC  = 500000,
    parameter int WRITE_CYC  = 250000,
    parameter int POLL_MAX   = 16,
    localparam int IDX_W     = $clog2(PAGE_BYTES),
    localparam int PC_W      = $clog2(POLL_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic [ADDR_W-1:0] byte_addr,
    input  logic [1:0]        fuse_sel,
    input  logic [7:0]        fuse_val,
    output logic [IDX_W-1:0]  pg_idx,
    input  logic [7:0]        pg_data,
    output logic              eng_valid,
    output logic [3:0]        eng_instr,
    output logic [15:0]       eng_data,
    input  logic              eng_done,
    input  logic [15:0]       eng_rdata,
    input  logic              eng_byte_stb,
    input  logic [7:0]        eng_rx_byte,
    output logic              busy,
    output logic              done,
    output logic              mismatch,
    output logic [IDX_W-1:0]  mismatch_off,
    output logic              fuse_err
);
    typedef enum logic [1:0] {S_IDLE, S_DISP, S_ISSUE, S_TIMER} state_e;

    state_e            state;
    op_e               op_q;
    logic [15:0]       waddr_q;
    logic [1:0]        fsel_q;
    logic [7:0]        fval_q;
    logic [STEP_W-1:0] sidx;
    logic [IDX_W:0]    bcnt;
    logic [PC_W-1:0]   pcnt;
    logic              done_q;
    logic              ferr_q;
    step_t             cur;
    logic              tmr_load;
    logic              tmr_exp;
    logic              accept;
    logic              cmp_en;

    assign accept = (state == S_IDLE) && start;

    fps_step_rom u_rom (
        .op   (op_q),
        .idx  (sidx),
        .hh   (waddr_q[15:8]),
        .ll   (waddr_q[7:0]),
        .fsel (fsel_q),
        .fval (fval_q),
        .step (cur)
    );

    assign tmr_load = (state == S_DISP) && (cur.kind == K_WAIT);

    fps_interval #(
        .LONG_CYC  (ERASE_CYC),
        .SHORT_CYC (WRITE_CYC)
    ) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .use_long (cur.word[0]),
        .expired  (tmr_exp)
    );

    always_comb begin
        if (cur.kind == K_READ) pg_idx = IDX_W'(bcnt - 1'b1);
        else                    pg_idx = IDX_W'(bcnt);
    end

    assign cmp_en = (state == S_ISSUE) && (cur.kind == K_READ) && eng_byte_stb &&
                    (bcnt != '0) && (bcnt <= (IDX_W+1)'(PAGE_BYTES));

    fps_cmp #(.IDX_W(IDX_W)) u_cmp (
        .clk      (clk),
        .rst      (rst),
        .clear    (accept),
        .en       (cmp_en),
        .off      (pg_idx),
        .got      (eng_rx_byte),
        .want     (pg_data),
        .flag     (mismatch),
        .flag_off (mismatch_off)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            op_q    <= OP_ERASE;
            waddr_q <= '0;
            fsel_q  <= '0;
            fval_q  <= '0;
            sidx    <= '0;
            bcnt    <= '0;
            pcnt    <= '0;
            done_q  <= 1'b0;
            ferr_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (start) begin
                        op_q    <= op_e'(op);
                        waddr_q <= 16'(byte_addr >> 1);
                        fsel_q  <= fuse_sel;
                        fval_q  <= fuse_val;
                        sidx    <= '0;
                        pcnt    <= '0;
                        ferr_q  <= 1'b0;
                        state   <= S_DISP;
                    end
                end
                S_DISP: begin
                    bcnt <= '0;
                    case (cur.kind)
                        K_END: begin
                            state  <= S_IDLE;
                            done_q <= 1'b1;
                        end
                        K_WAIT:  state <= S_TIMER;
                        default: state <= S_ISSUE;
                    endcase
                end
                S_ISSUE: begin
                    if (eng_byte_stb) bcnt <= bcnt + 1'b1;
                    if (eng_done) begin
                        state <= S_DISP;
                        if (cur.kind == K_POLL) begin
                            if (eng_rdata[POLL_BIT]) begin
                                sidx <= sidx + 1'b1;
                                pcnt <= '0;
                            end else if (pcnt == PC_W'(POLL_MAX - 1)) begin
                                ferr_q <= 1'b1;
                                sidx   <= sidx + 1'b1;
                                pcnt   <= '0;
                            end else begin
                                pcnt <= pcnt + 1'b1;
                            end
                        end else begin
                            sidx <= sidx + 1'b1;
                        end
                    end
                end
                default: begin
                    if (tmr_exp) begin
                        sidx  <= sidx + 1'b1;
                        state <= S_DISP;
                    end
                end
            endcase
        end
    end

    assign busy      = (state != S_IDLE);
    assign done      = done_q;
    assign fuse_err  = ferr_q;
    assign eng_valid = (state == S_ISSUE);
    assign eng_instr = cur.ir;
    assign eng_data  = cur.word;
endmodule

// File: rtl/fps_sequencer_chk.sv
module fps_sequencer_chk #(
    parameter int IDX_W = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             eng_valid,
    input logic             eng_done,
    input logic [3:0]       eng_instr,
    input logic [15:0]      eng_data,
    input logic             mismatch,
    input logic [IDX_W-1:0] mismatch_off
);
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    // R10
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);
    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !eng_valid);
    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (eng_valid && !eng_done) |=> (eng_valid && $stable(eng_instr) && $stable(eng_data)));
    // R12
    req_gap_chk: assert property (@(posedge clk) disable iff (rst)
        eng_done |=> !eng_valid);
    // R6
    mism_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mismatch && !(start && !busy)) |=> (mismatch && $stable(mismatch_off)));
endmodule

bind fps_sequencer fps_sequencer_chk #(.IDX_W(IDX_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .busy         (busy),
    .done         (done),
    .eng_valid    (eng_valid),
    .eng_done     (eng_done),
    .eng_instr    (eng_instr),
    .eng_data     (eng_data),
    .mismatch     (mismatch),
    .mismatch_off (mismatch_off)
);

// File: tb/sim_fps_sequencer.sv
module sim_fps_sequencer;
    localparam int PERIOD = 10;
    localparam int PB     = 128;
    localparam int ECYC   = 200;
    localparam int WCYC   = 120;
    localparam int PMAX   = 4;

    typedef struct packed {
        logic [1:0]  op;
        logic [16:0] addr;
        logic [1:0]  fsel;
        logic [7:0]  fval;
        logic [7:0]  hh;
        logic [7:0]  ll;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{2'd0, 17'h00000, 2'd0, 8'h00, 8'h00, 8'h00},
        '{2'd1, 17'h00100, 2'd0, 8'h00, 8'h00, 8'h80},
        '{2'd1, 17'h1A2C0, 2'd0, 8'h00, 8'hD1, 8'h60},
        '{2'd2, 17'h1A2C0, 2'd0, 8'h00, 8'hD1, 8'h60},
        '{2'd3, 17'h00000, 2'd0, 8'hE1, 8'h00, 8'h00},
        '{2'd3, 17'h00000, 2'd1, 8'h99, 8'h00, 8'h00},
        '{2'd3, 17'h00000, 2'd2, 8'hFB, 8'h00, 8'h00}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  op = '0;
    logic [16:0] byte_addr = '0;
    logic [1:0]  fuse_sel = '0;
    logic [7:0]  fuse_val = '0;
    logic [6:0]  pg_idx;
    logic [7:0]  pg_data;
    logic        eng_valid;
    logic [3:0]  eng_instr;
    logic [15:0] eng_data;
    logic        eng_done;
    logic [15:0] eng_rdata;
    logic        eng_byte_stb;
    logic [7:0]  eng_rx_byte;
    logic        busy, done, mismatch, fuse_err;
    logic [6:0]  mismatch_off;

    always #(PERIOD/2) clk = ~clk;

    fps_sequencer #(
        .ADDR_W(17), .PAGE_BYTES(PB), .ERASE_CYC(ECYC),
        .WRITE_CYC(WCYC), .POLL_MAX(PMAX)
    ) u0 (
        .clk(clk), .rst(rst), .start(start), .op(op), .byte_addr(byte_addr),
        .fuse_sel(fuse_sel), .fuse_val(fuse_val), .pg_idx(pg_idx), .pg_data(pg_data),
        .eng_valid(eng_valid), .eng_instr(eng_instr), .eng_data(eng_data),
        .eng_done(eng_done), .eng_rdata(eng_rdata), .eng_byte_stb(eng_byte_stb),
        .eng_rx_byte(eng_rx_byte), .busy(busy), .done(done), .mismatch(mismatch),
        .mismatch_off(mismatch_off), .fuse_err(fuse_err)
    );

    // page source and engine model state
    logic [7:0]  tb_page [PB];
    logic [7:0]  flash   [PB];
    assign pg_data = tb_page[pg_idx];

    int          cyc = 0;
    int          n_log = 0;
    logic [3:0]  log_i [1024];
    logic [15:0] log_d [1024];
    int          log_t [1024];
    int          poll_d = 2;
    int          ndone = 0;

    logic        e_busy = 1'b0;
    logic [3:0]  e_instr = '0;
    int          e_cnt = 0;
    int          e_nb = 0;
    int          fidx = 0;
    int          ld_ptr = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst && done) ndone <= ndone + 1;
        if (rst) begin
            e_busy       <= 1'b0;
            eng_done     <= 1'b0;
            eng_byte_stb <= 1'b0;
            eng_rdata    <= '0;
            eng_rx_byte  <= '0;
        end else begin
            eng_done     <= 1'b0;
            eng_byte_stb <= 1'b0;
            if (eng_byte_stb && e_instr == 4'h6) begin
                flash[ld_ptr % PB] <= pg_data;
                ld_ptr <= ld_ptr + 1;
            end
            if (!e_busy) begin
                if (eng_valid) begin
                    e_busy  <= 1'b1;
                    e_instr <= eng_instr;
                    e_cnt   <= 0;
                    e_nb    <= (eng_instr == 4'h6) ? PB : (eng_instr == 4'h7) ? PB + 1 : 0;
                    log_i[n_log] <= eng_instr;
                    log_d[n_log] <= eng_data;
                    log_t[n_log] <= cyc;
                    n_log <= n_log + 1;
                    if (eng_instr == 4'h6) ld_ptr <= 0;
                    if (eng_instr == 4'h5 && eng_data == 16'h2340) fidx <= 1;
                    else fidx <= fidx + 1;
                    eng_rdata <= (fidx >= 6 + poll_d) ? 16'h0200 : 16'h0000;
                end
            end else if (eng_done) begin
                e_busy <= 1'b0;
            end else begin
                e_cnt <= e_cnt + 1;
                if (e_cnt < e_nb) begin
                    eng_byte_stb <= 1'b1;
                    eng_rx_byte  <= (e_instr == 4'h7) ? ((e_cnt == 0) ? 8'hEE : flash[e_cnt - 1]) : 8'h00;
                end else if (e_cnt == e_nb + 1) begin
                    eng_done <= 1'b1;
                end
            end
        end
    end

    int ntests = 0;
    int nfail  = 0;
    logic [3:0]  exp_i [64];
    logic [15:0] exp_d [64];
    int ne = 0;
    int base = 0;

    task automatic check(string req, string what, int act, int expv);
        ntests++;
        if (act != expv) begin
            nfail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
        end
    endtask

    task automatic push(logic [3:0] i, logic [15:0] d);
        exp_i[ne] = i;
        exp_d[ne] = d;
        ne++;
    endtask

    task automatic build_exp(vec_t v, int d);
        logic [15:0] w;
        int np;
        ne = 0;
        push(4'hC, 16'h0001);
        push(4'h4, 16'hA370);
        case (v.op)
            2'd0: begin
                push(4'h5, 16'h2380); push(4'h5, 16'h3180);
                push(4'h5, 16'h3380); push(4'h5, 16'h3380);
            end
            2'd1: begin
                push(4'h5, 16'h2310); push(4'h5, {8'h07, v.hh}); push(4'h5, {8'h03, v.ll});
                push(4'h6, 16'h0000);
                push(4'h5, 16'h3700); push(4'h5, 16'h3500);
                push(4'h5, 16'h3700); push(4'h5, 16'h3700);
            end
            2'd2: begin
                push(4'h5, 16'h2302); push(4'h5, {8'h07, v.hh}); push(4'h5, {8'h03, v.ll});
                push(4'h7, 16'h0000);
            end
            default: begin
                push(4'h5, 16'h2340); push(4'h5, {8'h13, v.fval});
                w = (v.fsel == 2'd0) ? 16'h3300 : (v.fsel == 2'd1) ? 16'h3700 : 16'h3B00;
                push(4'h5, w); push(4'h5, w - 16'h0200); push(4'h5, w); push(4'h5, w);
                np = (d + 1 < PMAX) ? d + 1 : PMAX;
                for (int k = 0; k < np; k++) push(4'h5, 16'h3700);
            end
        endcase
        push(4'h5, 16'h2300); push(4'h5, 16'h3300);
        push(4'h4, 16'h0000); push(4'h C, 16'h0000);
    endtask

    task automatic check_seq(string req);
        int bad;
        bad = -1;
        check(req, "request count", n_log - base, ne);
        for (int k = 0; k < ne; k++)
            if (bad < 0 && (log_i[base + k] != exp_i[k] || log_d[base + k] != exp_d[k])) bad = k;
        if (bad >= 0)
            check(req, $sformatf("request %0d", bad),
                  {log_i[base + bad], log_d[base + bad]}, {exp_i[bad], exp_d[bad]});
        else
            check(req, "request list", 0, 0);
    endtask

    task automatic run_op(vec_t v);
        int n0;
        int lim;
        base = n_log;
        n0   = ndone;
        @(negedge clk);
        op = v.op; byte_addr = v.addr; fuse_sel = v.fsel; fuse_val = v.fval;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R10", "busy after start", busy, 1);
        lim = 0;
        while (ndone == n0 && lim < 20000) begin
            @(negedge clk);
            lim++;
        end
        check("R10", "done pulses", ndone - n0, 1);
        check("R10", "busy low at done", busy, 0);
        @(negedge clk);
        check("R10", "done one cycle", done, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

    initial begin
        vec_t v;
        int n0;
        for (int k = 0; k < PB; k++) tb_page[k] = 8'(k * 7 + 3);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check("R11", "busy", busy, 0);
        check("R11", "done", done, 0);
        check("R11", "eng_valid", eng_valid, 0);
        check("R11", "mismatch", mismatch, 0);
        check("R11", "fuse_err", fuse_err, 0);

        // table walk: R1, R2, R3, R4, R5, R7, R9
        for (int n = 0; n < 7; n++) begin
            v = VECS[n];
            poll_d = 2;
            run_op(v);
            build_exp(v, poll_d);
            check_seq("R1 R9 R12");
            case (v.op)
                2'd0: begin
                    check_seq("R2");
                    ntests++;
                    if (log_t[base + 6] - log_t[base + 5] < ECYC ||
                        log_t[base + 6] - log_t[base + 5] > ECYC + 8) begin
                        nfail++;
                        $display("FAIL R2 erase wait: actual %0d expected %0d..%0d",
                                 log_t[base + 6] - log_t[base + 5], ECYC, ECYC + 8);
                    end
                end
                2'd1: begin
                    check_seq("R3");
                    ntests++;
                    if (log_t[base + 10] - log_t[base + 9] < WCYC ||
                        log_t[base + 10] - log_t[base + 9] > WCYC + 8) begin
                        nfail++;
                        $display("FAIL R3 write wait: actual %0d expected %0d..%0d",
                                 log_t[base + 10] - log_t[base + 9], WCYC, WCYC + 8);
                    end
                    for (int k = 0; k < PB; k++)
                        if (flash[k] != tb_page[k])
                            check("R4", $sformatf("loaded byte %0d", k), flash[k], tb_page[k]);
                    check("R4", "bytes loaded", ld_ptr, PB);
                end
                2'd2: begin
                    check_seq("R5");
                    check("R5", "clean read-back mismatch", mismatch, 0);
                end
                default: begin
                    check_seq("R7");
                    check("R8", "fuse_err on quick poll", fuse_err, 0);
                end
            endcase
        end

        // R8: completion on the last allowed poll
        v = VECS[5];
        poll_d = PMAX - 1;
        run_op(v);
        build_exp(v, poll_d);
        check_seq("R8 last poll");
        check("R8", "fuse_err at last poll", fuse_err, 0);

        // R8: no completion, error raised and session closed
        poll_d = 100;
        run_op(v);
        build_exp(v, poll_d);
        check_seq("R8 R9 timeout");
        check("R8", "fuse_err on timeout", fuse_err, 1);

        // R6: two differences, first offset kept; error cleared by new start
        tb_page[9] = tb_page[9] ^ 8'h10;
        tb_page[5] = tb_page[5] ^ 8'h01;
        poll_d = 2;
        run_op(VECS[3]);
        check("R8", "fuse_err cleared by new start", fuse_err, 0);
        check("R6", "mismatch set", mismatch, 1);
        check("R6", "first offset", mismatch_off, 5);
        tb_page[9] = tb_page[9] ^ 8'h10;
        tb_page[5] = tb_page[5] ^ 8'h01;

        // R5 R6: last byte only
        tb_page[PB-1] = tb_page[PB-1] ^ 8'h80;
        run_op(VECS[3]);
        check("R6", "last byte mismatch", mismatch, 1);
        check("R6", "last byte offset", mismatch_off, PB - 1);
        tb_page[PB-1] = tb_page[PB-1] ^ 8'h80;
        run_op(VECS[3]);
        check("R6", "mismatch cleared on clean verify", mismatch, 0);

        // R10: start while busy is ignored
        base = n_log;
        n0 = ndone;
        @(negedge clk);
        op = 2'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        op = 2'd3; fuse_sel = 2'd1; fuse_val = 8'h55; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (ndone == n0) @(negedge clk);
        repeat (40) @(negedge clk);
        build_exp(VECS[0], 2);
        check_seq("R10 ignored start");
        check("R10", "single done", ndone - n0, 1);
        check("R10", "idle after ignored start", busy, 0);

        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end
endmodule